// File: doc/BRIEF.md
# Nested Fixed-Priority Interrupt Sequencer

This block decides when a small pipelined core should take an interrupt. It serves three channels, and each channel has a fixed rank. Channel 0 ranks highest and channel 2 lowest. Each channel holds a 4-bit mode code. The code picks which one-clock event pulse the channel listens to. A channel that sees its event becomes pending. At a fetch boundary that is not being flushed, the sequencer injects a call to the best eligible pending channel. That channel then counts as executing until its own return strobe arrives.

A channel may only be entered when no channel of equal or higher rank is executing. This lets a higher channel interrupt a lower one, but never the reverse. Software can block injection with a global lock command and re-allow it with a free command. After each injection, the next two fetch boundaries are skipped, so the pipeline flush that follows one call cannot swallow a second call. The injection request, the channel number, the jump-slot address and the per-channel state are all registered outputs.

Top module: `irq_nest_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `ch_state` is all zero and `inj_valid` is low. Injection is allowed and the spacing window is clear.
- R2: `ch_state[2i+1:2i]` holds channel i's state: 00 inactive, 01 pending, 10 executing. The code 11 never appears.
- R3: An inactive channel with mode m in 1..9 becomes pending at the next edge when `ev_src[m]` is high. Bit m of `ev_src` is the event for mode code m, and bit 0 is unused.
- R4: An event for a channel that is already pending or executing is dropped. Mode 0 and modes 10..15 ignore all events, and they return a pending channel to inactive at the next edge.
- R5: In a cycle with `fetch_stb` high and `flush` low, the lowest-numbered eligible pending channel is granted. In the next cycle `inj_valid` is high with `inj_ch`, and that channel reads 10. A flushed fetch grants nothing.
- R6: `inj_vec` gives the jump slot of the granted channel: 0x1F5 for channel 0, 0x1F3 for channel 1 and 0x1F1 for channel 2. The matching return slot is one below.
- R7: A pending channel i is not granted while any channel j <= i is executing. Channel 0 can therefore preempt channels 1 and 2, and channel 1 can preempt channel 2.
- R8: `ret_stb[i]` moves an executing channel i to inactive at the next edge. It has no effect on a channel that is not executing.
- R9: `glob_lock` blocks every grant from the next cycle on, and `glob_free` re-allows grants. When both are high in the same cycle, lock wins.
- R10: After a grant, the next two `fetch_stb` cycles (flushed or not) cannot grant. The third one can.
- R11: `mode_wr_en` writes `mode_wr_data` into the mode of channel `mode_wr_ch`. The new mode takes effect from the next cycle. A channel number of 3 writes nothing.
- R12: `inj_valid` never stays high two cycles in a row. While it is low, `inj_ch` and `inj_vec` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_src | input | 10 | One-clock event pulses, indexed by mode code |
| fetch_stb | input | 1 | Instruction-fetch boundary, one slot for an injection |
| flush | input | 1 | The current fetch slot is being discarded |
| ret_stb | input | 3 | Return executed for channel i |
| mode_wr_en | input | 1 | Mode write strobe |
| mode_wr_ch | input | 2 | Channel the mode write targets |
| mode_wr_data | input | 4 | New mode code |
| glob_lock | input | 1 | Block all injection |
| glob_free | input | 1 | Re-allow injection |
| inj_valid | output | 1 | Call injection request, one cycle |
| inj_ch | output | 2 | Granted channel |
| inj_vec | output | 9 | Jump-slot address of the granted channel |
| ch_state | output | 6 | Two state bits per channel |

## Verification
Several actions can land on the same clock edge. A grant to one channel can coincide with a return of another channel, a fresh event on a third, a mode change to off, and the expiry of the spacing window. A return can also coincide with a new event for the same channel. Directed sequences stage these collisions on purpose. A channel returns while a higher one sits pending behind the spacing window. A lock and a free arrive together. A flushed fetch lands just as the window opens. A long random run then drives dense events, fetch strobes, flushes, returns and mode writes together. A behavioural reference model judges every clock on state, grant, channel and slot address.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  // Per-channel progress code; the value 2'b11 is never produced.
  typedef enum logic [1:0] {
    CH_IDLE = 2'b00,
    CH_PEND = 2'b01,
    CH_EXEC = 2'b10
  } ch_state_e;

endpackage

// File: rtl/irq_src_sel.sv
module irq_src_sel #(
  parameter int NCH    = 3,
  parameter int MODE_W = 4,
  parameter int NSRC   = 10,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int NCODE = 2 ** MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [MODE_W-1:0] wr_data,
  input  logic [NSRC-1:0]   ev_src,
  output logic [NCH-1:0]    ev_hit,
  output logic [NCH-1:0]    mode_off
);

  // Event pulses widened to one bit per possible mode code.
  logic [NCODE-1:0] src_pad;

  always_comb begin
    src_pad = '0;
    for (int k = 1; k < NSRC && k < NCODE; k++) begin
      src_pad[k] = ev_src[k];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_mode
    logic [MODE_W-1:0] mode_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q <= '0;
      end else if (wr_en && (wr_ch == CH_W'(c))) begin
        mode_q <= wr_data;
      end
    end

    assign mode_off[c] = (mode_q == '0) || (int'(mode_q) >= NSRC);
    assign ev_hit[c]   = !mode_off[c] && src_pad[mode_q];
  end

endmodule

// File: rtl/irq_chan_fsm.sv
module irq_chan_fsm
  import irq_nest_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       grant,
  input  logic       ret,
  input  logic       ev_hit,
  input  logic       mode_off,
  output logic [1:0] st_o
);

  ch_state_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= CH_IDLE;
    end else begin
      unique case (st_q)
        CH_IDLE: if (ev_hit) st_q <= CH_PEND;
        CH_PEND: begin
          if (grant)         st_q <= CH_EXEC;
          else if (mode_off) st_q <= CH_IDLE;
        end
        CH_EXEC: if (ret) st_q <= CH_IDLE;
        default: st_q <= CH_IDLE;
      endcase
    end
  end

  assign st_o = st_q;

endmodule

// File: rtl/irq_inject_arb.sv
module irq_inject_arb #(
  parameter int NCH   = 3,
  parameter int VEC_W = 9,
  parameter logic [VEC_W-1:0] VEC_TOP = 9'h1F5,
  parameter int HOLD  = 2,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int HW   = $clog2(HOLD + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   pend,
  input  logic [NCH-1:0]   exec,
  input  logic [NCH-1:0]   off,
  input  logic             fetch_stb,
  input  logic             flush,
  input  logic             lock_cmd,
  input  logic             free_cmd,
  output logic [NCH-1:0]   grant,
  output logic             inj_valid,
  output logic [CH_W-1:0]  inj_ch,
  output logic [VEC_W-1:0] inj_vec
);

  logic            en_q;
  logic [HW-1:0]   hold_q;
  logic [NCH-1:0]  blocked;
  logic [NCH-1:0]  elig;
  logic            slot_ok;
  logic            hit;
  logic [CH_W-1:0] pick;

  // blocked[i]: some channel of rank i or better is executing.
  for (genvar i = 0; i < NCH; i++) begin : g_blk
    if (i == 0) begin : g_first
      assign blocked[i] = exec[i];
    end else begin : g_rest
      assign blocked[i] = blocked[i-1] | exec[i];
    end
    assign elig[i] = pend[i] & ~off[i] & ~blocked[i];
  end

  assign slot_ok = fetch_stb && !flush && en_q && (hold_q == '0);

  always_comb begin
    grant = '0;
    pick  = '0;
    hit   = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (slot_ok && elig[i] && !hit) begin
        grant[i] = 1'b1;
        pick     = CH_W'(i);
        hit      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b1;
      hold_q    <= '0;
      inj_valid <= 1'b0;
      inj_ch    <= '0;
      inj_vec   <= '0;
    end else begin
      if (lock_cmd)      en_q <= 1'b0;
      else if (free_cmd) en_q <= 1'b1;

      if (hit)                            hold_q <= HW'(HOLD);
      else if (fetch_stb && hold_q != '0) hold_q <= hold_q - 1'b1;

      inj_valid <= hit;
      inj_ch    <= hit ? pick : '0;
      inj_vec   <= hit ? (VEC_TOP - VEC_W'({pick, 1'b0})) : '0;
    end
  end

endmodule

// File: rtl/irq_nest_seq.sv
module irq_nest_seq #(
  parameter int NCH    = 3,
  parameter int MODE_W = 4,
  parameter int NSRC   = 10,
  parameter int VEC_W  = 9,
  parameter logic [VEC_W-1:0] VEC_TOP = 9'h1F5,
  parameter int HOLD   = 2,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    ev_src,
  input  logic               fetch_stb,
  input  logic               flush,
  input  logic [NCH-1:0]     ret_stb,
  input  logic               mode_wr_en,
  input  logic [CH_W-1:0]    mode_wr_ch,
  input  logic [MODE_W-1:0]  mode_wr_data,
  input  logic               glob_lock,
  input  logic               glob_free,
  output logic               inj_valid,
  output logic [CH_W-1:0]    inj_ch,
  output logic [VEC_W-1:0]   inj_vec,
  output logic [2*NCH-1:0]   ch_state
);

  logic [NCH-1:0] ev_hit;
  logic [NCH-1:0] mode_off;
  logic [NCH-1:0] grant;
  logic [NCH-1:0] pend;
  logic [NCH-1:0] exec;

  irq_src_sel #(
    .NCH(NCH), .MODE_W(MODE_W), .NSRC(NSRC)
  ) u_src (
    .clk(clk), .rst(rst),
    .wr_en(mode_wr_en), .wr_ch(mode_wr_ch), .wr_data(mode_wr_data),
    .ev_src(ev_src), .ev_hit(ev_hit), .mode_off(mode_off)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [1:0] st;

    irq_chan_fsm u_fsm (
      .clk(clk), .rst(rst),
      .grant(grant[c]), .ret(ret_stb[c]),
      .ev_hit(ev_hit[c]), .mode_off(mode_off[c]),
      .st_o(st)
    );

    assign pend[c]         = (st == irq_nest_pkg::CH_PEND);
    assign exec[c]         = (st == irq_nest_pkg::CH_EXEC);
    assign ch_state[2*c+:2] = st;
  end

  irq_inject_arb #(
    .NCH(NCH), .VEC_W(VEC_W), .VEC_TOP(VEC_TOP), .HOLD(HOLD)
  ) u_arb (
    .clk(clk), .rst(rst),
    .pend(pend), .exec(exec), .off(mode_off),
    .fetch_stb(fetch_stb), .flush(flush),
    .lock_cmd(glob_lock), .free_cmd(glob_free),
    .grant(grant),
    .inj_valid(inj_valid), .inj_ch(inj_ch), .inj_vec(inj_vec)
  );

endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
  parameter int NCH   = 3,
  parameter int CH_W  = 2,
  parameter int VEC_W = 9,
  parameter logic [VEC_W-1:0] VEC_TOP = 9'h1F5
) (
  input logic             clk,
  input logic             rst,
  input logic [NCH-1:0]   ret_stb,
  input logic             inj_valid,
  input logic [CH_W-1:0]  inj_ch,
  input logic [VEC_W-1:0] inj_vec,
  input logic [2*NCH-1:0] ch_state
);

  // True when the grant of channel ch was illegal given the prior state.
  function automatic logic pick_illegal(logic [2*NCH-1:0] st, logic [CH_W-1:0] ch);
    logic bad;
    bad = 1'b0;
    for (int j = 0; j < NCH; j++) begin
      if (j < int'(ch) && st[2*j+:2] == 2'b10) bad = 1'b1;
      if (j == int'(ch) && st[2*j+:2] != 2'b01) bad = 1'b1;
    end
    return bad;
  endfunction

  function automatic logic [1:0] st_of(logic [2*NCH-1:0] st, logic [CH_W-1:0] ch);
    logic [1:0] r;
    r = 2'b00;
    for (int j = 0; j < NCH; j++) begin
      if (j == int'(ch)) r = st[2*j+:2];
    end
    return r;
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_c
    assert_no_code11_R2: assert property (@(posedge clk) disable iff (rst)
      ch_state[2*c+:2] != 2'b11);

    assert_ret_to_idle_R8: assert property (@(posedge clk) disable iff (rst)
      (ch_state[2*c+:2] == 2'b10 && ret_stb[c]) |=> (ch_state[2*c+:2] == 2'b00));
  end

  assert_granted_exec_R5: assert property (@(posedge clk) disable iff (rst)
    inj_valid |-> (st_of(ch_state, inj_ch) == 2'b10));

  assert_slot_addr_R6: assert property (@(posedge clk) disable iff (rst)
    inj_valid |-> (inj_vec == VEC_TOP - VEC_W'({inj_ch, 1'b0})));

  assert_rank_rule_R7: assert property (@(posedge clk) disable iff (rst)
    inj_valid |-> !pick_illegal($past(ch_state), inj_ch));

  assert_spacing_R10: assert property (@(posedge clk) disable iff (rst)
    inj_valid |=> !inj_valid);

  assert_quiet_out_R12: assert property (@(posedge clk) disable iff (rst)
    !inj_valid |-> (inj_ch == '0 && inj_vec == '0));

endmodule

bind irq_nest_seq irq_nest_chk #(
  .NCH(NCH), .CH_W(CH_W), .VEC_W(VEC_W), .VEC_TOP(VEC_TOP)
) u_chk (
  .clk(clk), .rst(rst), .ret_stb(ret_stb),
  .inj_valid(inj_valid), .inj_ch(inj_ch), .inj_vec(inj_vec),
  .ch_state(ch_state)
);

// File: tb/test_irq_nest_seq.sv
`timescale 1ns/1ps
module test_irq_nest_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] ev_src = '0;
  logic       fetch_stb = 1'b0, flush = 1'b0;
  logic [2:0] ret_stb = '0;
  logic       mode_wr_en = 1'b0;
  logic [1:0] mode_wr_ch = '0;
  logic [3:0] mode_wr_data = '0;
  logic       glob_lock = 1'b0, glob_free = 1'b0;
  logic       inj_valid;
  logic [1:0] inj_ch;
  logic [8:0] inj_vec;
  logic [5:0] ch_state;

  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 0, done = 0;

  always #5 clk = ~clk;

  irq_nest_seq i_irq_nest_seq (
    .clk(clk), .rst(rst), .ev_src(ev_src), .fetch_stb(fetch_stb), .flush(flush),
    .ret_stb(ret_stb), .mode_wr_en(mode_wr_en), .mode_wr_ch(mode_wr_ch),
    .mode_wr_data(mode_wr_data), .glob_lock(glob_lock), .glob_free(glob_free),
    .inj_valid(inj_valid), .inj_ch(inj_ch), .inj_vec(inj_vec), .ch_state(ch_state)
  );

  // ---------------- behavioural reference model ----------------
  int m_st[3], m_md[3], n_st[3];
  int m_en, m_hold, m_iv, m_ich, m_vec, g;
  bit blk;

  function automatic bit live(int md);
    return md >= 1 && md <= 9;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) begin m_st[i] = 0; m_md[i] = 0; end
      m_en = 1; m_hold = 0; m_iv = 0; m_ich = 0; m_vec = 0;
    end else begin
      g = -1; blk = 0;
      for (int i = 0; i < 3; i++) begin
        blk = blk || (m_st[i] == 2);
        if (fetch_stb && !flush && m_en == 1 && m_hold == 0 && g < 0 &&
            !blk && m_st[i] == 1 && live(m_md[i])) g = i;
      end
      for (int i = 0; i < 3; i++) begin
        n_st[i] = m_st[i];
        if (g == i) n_st[i] = 2;
        else if (m_st[i] == 2 && ret_stb[i]) n_st[i] = 0;
        else if (m_st[i] == 1 && !live(m_md[i])) n_st[i] = 0;
        else if (m_st[i] == 0 && live(m_md[i]) && ev_src[m_md[i]]) n_st[i] = 1;
      end
      for (int i = 0; i < 3; i++) m_st[i] = n_st[i];
      if (g >= 0) m_hold = 2;
      else if (fetch_stb && m_hold > 0) m_hold = m_hold - 1;
      m_iv  = (g >= 0) ? 1 : 0;
      m_ich = (g >= 0) ? g : 0;
      m_vec = (g >= 0) ? ('h1F5 - 2 * g) : 0;
      if (mode_wr_en && mode_wr_ch < 3) m_md[mode_wr_ch] = mode_wr_data;
      if (glob_lock) m_en = 0;
      else if (glob_free) m_en = 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-clock comparison against the model.
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R2 state", int'(ch_state), m_st[2] * 16 + m_st[1] * 4 + m_st[0]);
      check("R5 inj_valid", int'(inj_valid), m_iv);
      check("R12 inj_ch", int'(inj_ch), m_ich);
      check("R6 inj_vec", int'(inj_vec), m_vec);
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  // Advance one clock; pulse inputs are cleared at the following falling edge.
  task automatic tick();
    @(negedge clk);
    ev_src = '0; fetch_stb = 0; flush = 0; ret_stb = '0;
    mode_wr_en = 0; glob_lock = 0; glob_free = 0;
  endtask

  task automatic wmode(input int ch, input int md);
    mode_wr_en = 1; mode_wr_ch = 2'(ch); mode_wr_data = 4'(md); tick();
  endtask

  task automatic fetch_n(input int n);
    for (int k = 0; k < n; k++) begin fetch_stb = 1; tick(); end
  endtask

  initial begin
    tick(); tick(); tick();
    rst = 0;
    tick();
    cmp_on = 1;
    check("R1 reset state", int'(ch_state), 0);
    check("R1 reset inj", int'(inj_valid), 0);

    wmode(0, 1); wmode(1, 5); wmode(2, 9);                 // R11
    ev_src[1] = 1; tick();
    check("R3 pend ch0", int'(ch_state), 'h01);
    ev_src[1] = 1; ev_src[7] = 1; tick();
    check("R4 dropped event", int'(ch_state), 'h01);
    fetch_stb = 1; tick();
    check("R5 inj", int'(inj_valid), 1);
    check("R6 vec ch0", int'(inj_vec), 'h1F5);
    check("R5 state", int'(ch_state), 'h02);
    tick();
    check("R12 pulse", int'(inj_valid), 0);

    ev_src[5] = 1; ev_src[9] = 1; tick();
    check("R3 pend ch1 ch2", int'(ch_state), 'h16);
    fetch_n(3);
    check("R7 blocked by ch0", int'(inj_valid), 0);
    check("R7 state", int'(ch_state), 'h16);
    ret_stb = 3'b010; tick();
    check("R8 ret ignored", int'(ch_state), 'h16);
    ret_stb = 3'b001; tick();
    check("R8 ret ch0", int'(ch_state), 'h14);
    fetch_stb = 1; tick();
    check("R6 vec ch1", int'(inj_vec), 'h1F3);
    check("R11 mode ch1", int'(ch_state), 'h18);

    ev_src[1] = 1; tick();
    fetch_n(2);
    check("R10 spacing", int'(inj_valid), 0);
    fetch_stb = 1; tick();
    check("R10 third fetch", int'(inj_valid), 1);
    check("R7 preempt ch0", int'(inj_ch), 0);

    ret_stb = 3'b001; tick();
    ret_stb = 3'b010; tick();
    glob_lock = 1; tick();
    fetch_n(3);
    check("R9 locked", int'(inj_valid), 0);
    glob_lock = 1; glob_free = 1; tick();
    fetch_n(1);
    check("R9 lock wins", int'(inj_valid), 0);
    glob_free = 1; tick();
    fetch_stb = 1; flush = 1; tick();
    check("R5 flushed fetch", int'(inj_valid), 0);
    fetch_stb = 1; tick();
    check("R6 vec ch2", int'(inj_vec), 'h1F1);
    check("R5 ch2 exec", int'(ch_state), 'h20);

    ret_stb = 3'b100; tick();
    ev_src[5] = 1; tick();
    check("R3 pend again", int'(ch_state), 'h04);
    wmode(1, 12);
    tick();
    check("R4 unused mode clears", int'(ch_state), 'h00);

    // Dense random traffic, judged clock by clock against the model.
    for (int n = 0; n < 5000; n++) begin
      for (int b = 0; b < 10; b++) ev_src[b] = ($urandom % 6 == 0);
      fetch_stb = $urandom % 2;
      flush = ($urandom % 8 == 0);
      for (int b = 0; b < 3; b++) ret_stb[b] = ($urandom % 5 == 0);
      if ($urandom % 12 == 0) begin
        mode_wr_en = 1; mode_wr_ch = 2'($urandom % 4); mode_wr_data = 4'($urandom % 16);
      end
      glob_lock = ($urandom % 40 == 0);
      glob_free = ($urandom % 10 == 0);
      tick();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule